// File: doc/BRIEF.md
# PWM Generator with Duty-Sample FIFO

This block is a single-channel pulse-width modulator that sits on a simple register bus with address, write strobe, read strobe and data. Software sets a clock divider and a period, then writes duty values into a four-word sample FIFO. The generator takes one duty value from the FIFO at the start of every PWM period. Software can therefore queue a few future duty cycles ahead of time and update the waveform without tracking period boundaries.

A 12-bit prescaler divides the clock into ticks. A period counter runs over `P + 2` ticks, where `P` is the 16-bit period register. The output is high while the counter is below the current duty value. A self-clearing software reset returns every register to zero and empties the FIFO.

The control core is a four-state machine:
- **OFF**: counters held at zero, output low. Moves to LOAD when the enable bit is set.
- **LOAD**: lasts one cycle. It takes the first duty value from the FIFO and always moves to RUN.
- **RUN**: prescaler and period counter run. It moves back to OFF when the enable bit reads as cleared.
- **SWRST**: entered from any state by a control write with the reset bit set. It stays there for exactly four cycles and then returns to OFF.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset every register reads 0 (control 0x00, status 0x04, sample 0x0C, period 0x10) and `pwm_out` is low.
- R2: The control register keeps the bits selected by mask 0x01C3FFF1: bit 0 is enable, bits 15:4 are the divide ratio minus one, and bits 17:16 and 24:22 are stored with no effect on the output. Other written bits read back as 0. The period register keeps bits 15:0. Reads of any other offset return 0.
- R3: Each write to offset 0x0C pushes bits 15:0 of the data into the FIFO. Status bits 2:0 report the FIFO occupancy. A write made while the occupancy is 4 is dropped.
- R4: In RUN, one PWM period lasts `(P+2)*(N+1)` clocks, where `N` is the prescaler field. The output is high for the first `D` ticks of the period, where `D` is the current duty value, and low for the remaining ticks.
- R5: With enable set, OFF moves to LOAD on the next clock. LOAD pops the FIFO head into the duty register, and RUN starts the cycle after, with both counters at zero.
- R6: One FIFO entry is popped at the end of each period. If the FIFO is empty at that point, the previous duty value is kept. The sample register reads back the duty value currently in use.
- R7: A duty value of 0 gives a constant low output. A duty value of `P+2` or more gives a constant high output.
- R8: When enable is cleared, the block returns to OFF within one cycle. The output stays low, the FIFO contents are kept and the duty value is kept.
- R9: A control write with bit 3 set enters SWRST. Control bit 3 then reads 1 for exactly 4 cycles, and every bus write during that time is ignored. Afterwards all registers read 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; gates `bus_rdata` |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
The checker watches several properties on every cycle:
- the FIFO occupancy never exceeds four;
- a write to a full FIFO in OFF leaves the occupancy at four;
- LOAD consumes exactly one entry;
- a zero duty value never produces a high output;
- a disabled block holds its output low;
- a software reset empties the FIFO at once and lasts no longer than four cycles.

Other behaviours only the bench scenarios can show, by comparing `pwm_out` on every clock against a behavioural model and by running directed reads:
- the exact high and low lengths under a prescaler;
- reuse of the last duty value when the FIFO runs dry;
- register readback masking;
- the constant-high case;
- keeping the FIFO contents across a disable.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_STAT   = 'h04;
    localparam int OFS_SAMPLE = 'h0C;
    localparam int OFS_PERIOD = 'h10;
    localparam logic [31:0] CTRL_KEEP_MASK = 32'h01C3_FFF1;
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SWR_BIT = 3;
    localparam int PRESC_LSB    = 4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2,
        ST_SWRST = 2'd3
    } gen_state_e;
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (count != CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int PSW = 12,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           active,
    input  logic           clear,
    input  logic [PSW-1:0] presc,
    input  logic [CW-1:0]  period,
    input  logic [CW-1:0]  duty,
    output logic           wrap,
    output logic           level
);
    logic [PSW-1:0] ps_q;
    logic [CW:0]    cnt_q;
    logic [CW:0]    last;
    logic           tick;

    assign last  = {1'b0, period} + (CW+1)'(1);
    assign tick  = active && !clear && (ps_q == presc);
    assign wrap  = tick && (cnt_q >= last);
    assign level = active && (cnt_q < {1'b0, duty});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q  <= '0;
            cnt_q <= '0;
        end else if (!active || clear) begin
            ps_q  <= '0;
            cnt_q <= '0;
        end else if (ps_q == presc) begin
            ps_q  <= '0;
            cnt_q <= (cnt_q >= last) ? '0 : cnt_q + 1'b1;
        end else begin
            ps_q  <= ps_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int PSW        = 12,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 4,
    parameter int SWR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    localparam int FCW = $clog2(FIFO_DEPTH + 1);
    localparam int RCW = (SWR_CYCLES > 1) ? $clog2(SWR_CYCLES) : 1;

    gen_state_e       state_q, state_d;
    logic [31:0]      ctrl_q;
    logic [CNT_W-1:0] period_q, duty_q;
    logic [RCW-1:0]   rst_cnt_q;
    logic [FCW-1:0]   fifo_count;
    logic [CNT_W-1:0] fifo_head;
    logic             swr_busy, wr_ok, wr_ctrl, swr_req, flush;
    logic             wrap, level, pop_req, duty_load;
    logic [31:0]      rd_mux;

    assign swr_busy  = (state_q == ST_SWRST);
    assign wr_ok     = bus_wr && !swr_busy;
    assign wr_ctrl   = wr_ok && (bus_addr == ADDR_W'(OFS_CTRL));
    assign swr_req   = wr_ctrl && bus_wdata[CTRL_SWR_BIT];
    assign flush     = swr_req || swr_busy;
    assign pop_req   = (state_q == ST_LOAD) || wrap;
    assign duty_load = pop_req && (fifo_count != '0) && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (swr_req) begin
            state_d = ST_SWRST;
        end else begin
            unique case (state_q)
                ST_OFF:   if (ctrl_q[CTRL_EN_BIT]) state_d = ST_LOAD;
                ST_LOAD:  state_d = ST_RUN;
                ST_RUN:   if (!ctrl_q[CTRL_EN_BIT]) state_d = ST_OFF;
                ST_SWRST: if (rst_cnt_q == RCW'(SWR_CYCLES - 1)) state_d = ST_OFF;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            period_q  <= '0;
            duty_q    <= '0;
            rst_cnt_q <= '0;
        end else if (flush) begin
            ctrl_q    <= '0;
            period_q  <= '0;
            duty_q    <= '0;
            rst_cnt_q <= swr_req ? '0 : rst_cnt_q + 1'b1;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_KEEP_MASK;
            if (wr_ok && bus_addr == ADDR_W'(OFS_PERIOD)) period_q <= bus_wdata[CNT_W-1:0];
            if (duty_load) duty_q <= fifo_head;
        end
    end

    pwm_sample_fifo #(.DW(CNT_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (wr_ok && bus_addr == ADDR_W'(OFS_SAMPLE)),
        .push_data (bus_wdata[CNT_W-1:0]),
        .pop       (pop_req),
        .head      (fifo_head),
        .count     (fifo_count)
    );

    pwm_timebase #(.PSW(PSW), .CW(CNT_W)) tb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state_q == ST_RUN),
        .clear  (swr_req),
        .presc  (ctrl_q[PRESC_LSB +: PSW]),
        .period (period_q),
        .duty   (duty_q),
        .wrap   (wrap),
        .level  (level)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL))
            rd_mux = ctrl_q | (32'(swr_busy) << CTRL_SWR_BIT);
        else if (bus_addr == ADDR_W'(OFS_STAT))
            rd_mux = 32'(fifo_count);
        else if (bus_addr == ADDR_W'(OFS_SAMPLE))
            rd_mux = 32'(duty_q);
        else if (bus_addr == ADDR_W'(OFS_PERIOD))
            rd_mux = 32'(period_q);
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
    assign pwm_out   = level;
endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk
    import pwm_fifo_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [1:0]  state,
    input logic [2:0]  fifo_count,
    input logic [15:0] duty,
    input logic        ctrl_en,
    input logic        swr_busy,
    input logic        pwm_out
);
    logic [2:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      busy_run <= '0;
        else if (!swr_busy)              busy_run <= '0;
        else if (busy_run != 3'd7)       busy_run <= busy_run + 1'b1;
    end

    assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= 3'd4);

    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'(OFS_SAMPLE) && fifo_count == 3'd4 && state == 2'(ST_OFF))
        |=> (fifo_count == 3'd4));

    assert_load_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(ST_LOAD) && fifo_count != 3'd0 && !(bus_wr && bus_addr == 5'(OFS_SAMPLE)))
        |=> (fifo_count == $past(fifo_count) - 3'd1));

    assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (duty == 16'd0) |-> !pwm_out);

    assert_off_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && $past(!ctrl_en)) |-> !pwm_out);

    assert_swr_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'(OFS_CTRL) && bus_wdata[CTRL_SWR_BIT] && !swr_busy)
        |=> (fifo_count == 3'd0 && swr_busy));

    assert_swr_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(swr_busy && busy_run >= 3'd4));
endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .state      (state_q),
    .fifo_count (fifo_count),
    .duty       (duty_q),
    .ctrl_en    (ctrl_q[0]),
    .swr_busy   (swr_busy),
    .pwm_out    (pwm_out)
);

// File: tb/pwm_fifo_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_fifo_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_total = 0;
    int n_fail  = 0;
    bit track   = 1'b0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    pwm_fifo_gen dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // behavioural reference model
    int m_state, m_ps, m_cnt, m_duty, m_ctrl, m_period, m_swr;
    int m_q[$];
    int presc, last, ns;
    bit tick, popr, full;

    initial begin
        m_state = 0; m_ps = 0; m_cnt = 0; m_duty = 0;
        m_ctrl = 0; m_period = 0; m_swr = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_ps = 0; m_cnt = 0; m_duty = 0;
            m_ctrl = 0; m_period = 0; m_swr = 0; m_q.delete();
        end else if (m_swr > 0) begin
            m_swr = m_swr - 1;
        end else if (bus_wr && bus_addr == 0 && bus_wdata[3]) begin
            m_swr = 4; m_ctrl = 0; m_period = 0; m_duty = 0;
            m_state = 0; m_ps = 0; m_cnt = 0; m_q.delete();
        end else begin
            presc = (m_ctrl >> 4) & 'hFFF;
            last  = m_period + 1;
            tick  = (m_state == 2) && (m_ps == presc);
            popr  = (m_state == 1) || (tick && m_cnt >= last);
            full  = (m_q.size() == 4);
            ns = m_state;
            if (m_state == 0 && (m_ctrl & 1) != 0) ns = 1;
            else if (m_state == 1) ns = 2;
            else if (m_state == 2 && (m_ctrl & 1) == 0) ns = 0;
            if (m_state == 2) begin
                if (tick) begin
                    m_ps = 0;
                    m_cnt = (m_cnt >= last) ? 0 : m_cnt + 1;
                end else m_ps = m_ps + 1;
            end else begin
                m_ps = 0; m_cnt = 0;
            end
            if (popr && m_q.size() > 0) m_duty = m_q.pop_front();
            if (bus_wr && bus_addr == 12 && !full) m_q.push_back(int'(bus_wdata[15:0]));
            if (bus_wr && bus_addr == 0)  m_ctrl = int'(bus_wdata & 32'h01C3FFF1);
            if (bus_wr && bus_addr == 16) m_period = int'(bus_wdata[15:0]);
            m_state = ns;
        end
    end

    function automatic int model_read(int a);
        if (a == 0)  return m_ctrl | ((m_swr > 0) ? 8 : 0);
        if (a == 4)  return m_q.size();
        if (a == 12) return m_duty;
        if (a == 16) return m_period;
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock waveform comparison
    always @(negedge clk) begin
        if (rst_n && track && !done)
            chk(pwm_out === ((m_state == 2) && (m_cnt < m_duty)), "R4 pwm_out vs model",
                int'(pwm_out), int'((m_state == 2) && (m_cnt < m_duty)));
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = 5'(a); bus_wdata = 32'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        @(negedge clk);
        bus_addr = 5'(a); bus_rd = 1'b1;
        #1;
        chk(bus_rdata === 32'(exp), tag, int'(bus_rdata), exp);
        chk(bus_rdata === 32'(model_read(a)), {tag, " model"}, int'(bus_rdata), model_read(a));
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_level(bit lvl, int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(pwm_out === lvl, tag, int'(pwm_out), int'(lvl));
        end
    endtask

    task automatic measure(output int hi, output int lo);
        int guard;
        guard = 0; hi = 0; lo = 0;
        while (pwm_out !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
        while (pwm_out !== 1'b1 && guard < 400) begin @(negedge clk); guard++; end
        while (pwm_out === 1'b1 && guard < 600) begin hi++; @(negedge clk); guard++; end
        while (pwm_out === 1'b0 && guard < 800) begin lo++; @(negedge clk); guard++; end
    endtask

    initial begin
        #500us;
        if (!done) begin
            done = 1'b1;
            n_total++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int hi, lo, busy;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        track = 1'b1;

        // R1: reset values
        rd(0, 0, "R1 ctrl");
        rd(4, 0, "R1 status");
        rd(12, 0, "R1 sample");
        rd(16, 0, "R1 period");
        chk(pwm_out === 1'b0, "R1 pwm_out", int'(pwm_out), 0);

        // R2: masking and map
        wr(0, 32'hFFC3FFF6);
        rd(0, 32'h01C3FFF0, "R2 ctrl mask");
        wr(0, 0);
        wr(16, 32'h0001ABCD);
        rd(16, 32'hABCD, "R2 period width");
        rd(8, 0, "R2 unmapped 0x08");
        rd(20, 0, "R2 unmapped 0x14");

        // R3: fill and overflow
        wr(16, 4);
        wr(12, 2); rd(4, 1, "R3 count 1");
        wr(12, 5); rd(4, 2, "R3 count 2");
        wr(12, 0); rd(4, 3, "R3 count 3");
        wr(12, 7); rd(4, 4, "R3 count 4");
        wr(12, 3); rd(4, 4, "R3 full drop");
        rd(12, 0, "R3 sample unchanged");

        // R5: start-up
        wr(0, 1);
        idle(1);
        rd(4, 3, "R5 first pop");
        rd(12, 2, "R5 first duty");

        // R6 / R7: drain, reuse, constant high
        idle(40);
        rd(4, 0, "R6 drained");
        rd(12, 7, "R6 reuse last");
        hold_level(1'b1, 12, "R7 duty>=P+2 high");
        wr(12, 0);
        idle(12);
        rd(12, 0, "R7 zero duty loaded");
        hold_level(1'b0, 12, "R7 zero duty low");

        // R4: prescaler /3, period 2 -> 12 clocks, duty 3 -> 9 high; R2 inert bits set
        wr(0, 32'h00410021);
        wr(16, 2);
        wr(12, 3);
        idle(30);
        measure(hi, lo);
        chk(hi == 9, "R4 high length", hi, 9);
        chk(lo == 3, "R4 low length", lo, 3);

        // R8: disable keeps FIFO and duty
        wr(0, 0);
        idle(2);
        wr(12, 4);
        wr(12, 6);
        idle(20);
        rd(4, 2, "R8 fifo kept");
        rd(12, 3, "R8 duty kept");
        hold_level(1'b0, 10, "R8 output low");
        wr(0, 1);
        idle(1);
        rd(12, 4, "R8 kept entry used");

        // R9: software reset
        wr(0, 9);
        rd(0, 8, "R9 busy bit");
        wr(16, 32'h55);
        rd(0, 0, "R9 ctrl cleared");
        rd(16, 0, "R9 write ignored");
        rd(4, 0, "R9 fifo empty");
        rd(12, 0, "R9 duty cleared");
        wr(12, 9);
        wr(0, 8);
        busy = 0;
        bus_addr = 5'(0); bus_rd = 1'b1;
        for (int i = 0; i < 10; i++) begin
            #1;
            if (bus_rdata[3]) busy++;
            @(negedge clk);
        end
        bus_rd = 1'b0;
        chk(busy == 4, "R9 busy length", busy, 4);
        wr(12, 5);
        wr(0, 8);
        wr(12, 6);
        idle(6);
        rd(4, 0, "R9 push during busy ignored");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule